// File: doc/BRIEF.md
# Banked GPIO Register Block

This block holds a parameterised number of byte-wide GPIO banks behind a plain register bus made of an address, write data, a write strobe and a combinational read data return. Each bank has a window of four byte registers at consecutive addresses. The registers hold the pin direction, the output latch, the synchronised pin level and the per-pin drive mode. Bank windows start at a top base address and step downward by a fixed stride. A bank may implement fewer than eight pins.

On the pin side, every pin has a drive-enable, a drive value and an input. A pin set as an output either drives its latch value directly in push-pull mode, or in open-drain mode pulls low only when its latch bit is 0. Software changes one pin at a time by read-modify-write, so every writable register returns exactly the implemented bits that were last written.

Top module: `gpio_bank_regs`

## Requirements
- R1: Bank b owns addresses TOP_BASE - b*STRIDE + k. The default is 0xF0 - 0x10*b. The offset k selects the register: 0 is direction, 1 is output latch, 2 is pin input, and 3 is drive mode. Bank b's pin p is pin index b*8+p on the pin buses.
- R2: The direction, output latch and mode registers read back the value last written, masked to the bank's implemented pins.
- R3: A direction bit of 0 makes the pin an input, so its drive-enable is 0. A direction bit of 1 makes it an output.
- R4: An output pin with mode bit 1 (push-pull) has drive-enable 1 and a drive value equal to its latch bit.
- R5: An output pin with mode bit 0 (open-drain) has drive-enable 1 and drive value 0 when its latch bit is 0. When its latch bit is 1, its drive-enable is 0.
- R6: The input register returns each pin level through a two-flop synchroniser, whatever the pin direction. A pin change first shows on a read after the second rising clock edge.
- R7: Bits of unimplemented pins read as 0 in every register and ignore writes. Their drive-enable and drive value stay 0. The default pin counts for banks 0..7 are 6, 8, 8, 8, 8, 5, 8 and 4.
- R8: Reset clears direction, output latch, mode and the synchroniser stages, so every pin is an input.
- R9: Reads of an address outside every bank's four registers return 0x00. Writes there, and writes to an input register, change nothing.
- R10: A write takes effect at the rising clock edge where the write strobe is 1. An address and data presented with the strobe at 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_BANKS*8 | Pin levels, asynchronous to clk |
| pin_oe | output | NUM_BANKS*8 | Per-pin drive-enable |
| pin_out | output | NUM_BANKS*8 | Per-pin drive value |

## Verification
Four behaviours are checked on every cycle:
- reads outside the bank windows return zero;
- a written register returns the masked write data on the next cycle;
- unimplemented pins never drive;
- the input register matches a pin held steady for three cycles.

A property also holds all drive-enables low right after reset. The open-drain and push-pull drive equations, the exact two-edge latency of the synchroniser, the effect of a disabled write strobe, and ignored writes to input registers and holes are shown only by the bench's scenarios. In those scenarios a reference model of the registers predicts every read and every pin byte.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned GPIO_W   = 8;
   localparam int unsigned REG_SPAN = 4;

   typedef enum logic [1:0] {
      OFS_DIR  = 2'd0,
      OFS_DOUT = 2'd1,
      OFS_DIN  = 2'd2,
      OFS_MODE = 2'd3
   } gpio_ofs_e;

   function automatic logic [GPIO_W-1:0] pin_mask(int unsigned n);
      if (n >= GPIO_W) return '1;
      return GPIO_W'((1 << n) - 1);
   endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int                ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE   = '0,
   parameter int                NPINS  = 8,
   parameter int                SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [GPIO_W-1:0] wdata,
   input  logic              we,
   input  logic [GPIO_W-1:0] pin_in,
   output logic [GPIO_W-1:0] rdata,
   output logic [GPIO_W-1:0] oe,
   output logic [GPIO_W-1:0] dout
);
   localparam logic [GPIO_W-1:0] MASK = pin_mask(NPINS);

   logic [ADDR_W-1:0] offs;
   logic              hit;
   gpio_ofs_e         sel;
   logic [GPIO_W-1:0] dir_q, out_q, mode_q, din;
   logic [NPINS-1:0]  sync_q;
   logic              unused_hi;

   assign offs = addr - BASE;
   assign hit  = offs < ADDR_W'(REG_SPAN);
   assign sel  = gpio_ofs_e'(offs[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         mode_q <= '0;
      end else if (we && hit) begin
         case (sel)
            OFS_DIR:  dir_q  <= wdata & MASK;
            OFS_DOUT: out_q  <= wdata & MASK;
            OFS_MODE: mode_q <= wdata & MASK;
            default:  ;
         endcase
      end
   end

   gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in[NPINS-1:0]),
      .q     (sync_q)
   );

   generate
      if (NPINS < GPIO_W) begin : g_part
         assign din       = {{(GPIO_W-NPINS){1'b0}}, sync_q};
         assign unused_hi = ^pin_in[GPIO_W-1:NPINS];
      end else begin : g_full
         assign din       = sync_q;
         assign unused_hi = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (sel)
            OFS_DIR:  rdata = dir_q;
            OFS_DOUT: rdata = out_q;
            OFS_DIN:  rdata = din;
            OFS_MODE: rdata = mode_q;
            default:  rdata = '0;
         endcase
      end
   end

   // push-pull: enable whenever output; open-drain: enable only to pull low
   assign oe   = dir_q & (mode_q | ~out_q);
   assign dout = dir_q & mode_q & out_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int                      NUM_BANKS = 8,
   parameter int                      ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]       TOP_BASE  = 8'hF0,
   parameter logic [ADDR_W-1:0]       STRIDE    = 8'h10,
   parameter logic [NUM_BANKS*4-1:0]  BANK_PINS = 32'h4858_8886,
   parameter int                      SYNC_N    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [7:0]                  bus_wdata,
   input  logic                        bus_we,
   output logic [7:0]                  bus_rdata,
   input  logic [NUM_BANKS*GPIO_W-1:0] pin_in,
   output logic [NUM_BANKS*GPIO_W-1:0] pin_oe,
   output logic [NUM_BANKS*GPIO_W-1:0] pin_out
);
   logic [GPIO_W-1:0] bank_rd [NUM_BANKS];

   generate
      if (int'(STRIDE) < int'(REG_SPAN)) begin : g_bad_stride
         $error("STRIDE smaller than the register window");
      end
      if (int'(TOP_BASE) < (NUM_BANKS-1)*int'(STRIDE)) begin : g_bad_base
         $error("TOP_BASE too low for NUM_BANKS");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("SYNC_N must be at least 2");
      end

      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int                NP     = int'(BANK_PINS[b*4 +: 4]);
         localparam logic [ADDR_W-1:0] BASE_B = ADDR_W'(int'(TOP_BASE) - b*int'(STRIDE));
         if (NP < 1 || NP > int'(GPIO_W)) begin : g_bad_np
            $error("bank pin count out of range");
         end
         gpio_bank #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE_B),
            .NPINS  (NP),
            .SYNC_N (SYNC_N)
         ) i_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr   (bus_addr),
            .wdata  (bus_wdata),
            .we     (bus_we),
            .pin_in (pin_in[b*GPIO_W +: GPIO_W]),
            .rdata  (bank_rd[b]),
            .oe     (pin_oe[b*GPIO_W +: GPIO_W]),
            .dout   (pin_out[b*GPIO_W +: GPIO_W])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= bank_rd[b];
   end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
   import gpio_bank_pkg::*;
#(
   parameter int                      NUM_BANKS = 8,
   parameter int                      ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]       TOP_BASE  = 8'hF0,
   parameter logic [ADDR_W-1:0]       STRIDE    = 8'h10,
   parameter logic [NUM_BANKS*4-1:0]  BANK_PINS = 32'h4858_8886
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [7:0]                  bus_wdata,
   input logic                        bus_we,
   input logic [7:0]                  bus_rdata,
   input logic [NUM_BANKS*GPIO_W-1:0] pin_in,
   input logic [NUM_BANKS*GPIO_W-1:0] pin_oe,
   input logic [NUM_BANKS*GPIO_W-1:0] pin_out
);
   function automatic int bank_of(logic [ADDR_W-1:0] a);
      for (int b = 0; b < NUM_BANKS; b++) begin
         logic [ADDR_W-1:0] o;
         o = a - ADDR_W'(int'(TOP_BASE) - b*int'(STRIDE));
         if (o < ADDR_W'(REG_SPAN)) return b;
      end
      return -1;
   endfunction

   function automatic logic [1:0] ofs_of(logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] o;
      o = a - ADDR_W'(int'(TOP_BASE) - bank_of(a)*int'(STRIDE));
      return o[1:0];
   endfunction

   function automatic logic [7:0] mask_of(int b);
      if (b < 0) return '0;
      return pin_mask(int'(BANK_PINS[b*4 +: 4]));
   endfunction

   function automatic logic [NUM_BANKS*GPIO_W-1:0] impl_all();
      logic [NUM_BANKS*GPIO_W-1:0] m;
      for (int b = 0; b < NUM_BANKS; b++) m[b*GPIO_W +: GPIO_W] = mask_of(b);
      return m;
   endfunction

   function automatic logic [7:0] pins_of(int b);
      return 8'(pin_in >> (b*GPIO_W));
   endfunction

   localparam logic [NUM_BANKS*GPIO_W-1:0] IMPL = impl_all();

   logic [1:0] up_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            up_cnt <= '0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_of(bus_addr) < 0) |-> (bus_rdata == 8'h00)); // R9

   AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bank_of(bus_addr) >= 0 && ofs_of(bus_addr) != 2'd2)
      |=> ($stable(bus_addr) |-> (bus_rdata == ($past(bus_wdata) & mask_of(bank_of(bus_addr)))))); // R2

   AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~IMPL) == '0) && ((pin_out & ~IMPL) == '0)); // R7

   AST_RESET_ALL_INPUT: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0)); // R8

   AST_INPUT_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd3 && bank_of(bus_addr) >= 0 && ofs_of(bus_addr) == 2'd2
       && $stable(pin_in) && $past($stable(pin_in)))
      |-> (bus_rdata == (pins_of(bank_of(bus_addr)) & mask_of(bank_of(bus_addr))))); // R6
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .TOP_BASE  (TOP_BASE),
   .STRIDE    (STRIDE),
   .BANK_PINS (BANK_PINS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
   typedef struct {
      int         kind;   // 0 read data, 1 drive-enable byte, 2 drive value byte
      int         bank;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_rdata;
   logic [63:0] pin_in = '0;
   logic [63:0] pin_oe, pin_out;

   int n_cmp = 0;
   int n_bad = 0;
   item_t sb_q[$];
   event  chk_ev;
   bit    done = 1'b0;

   int         pins [8] = '{6, 8, 8, 8, 8, 5, 8, 4};
   logic [7:0] m_dir [8];
   logic [7:0] m_out [8];
   logic [7:0] m_mode [8];

   always #4 clk = ~clk;

   gpio_bank_regs i_gpio_bank_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out)
   );

   function automatic logic [7:0] msk(int b);
      return 8'((1 << pins[b]) - 1);
   endfunction

   function automatic logic [7:0] exp_oe(int b);
      return m_dir[b] & (m_mode[b] | ~m_out[b]) & msk(b);
   endfunction

   function automatic logic [7:0] exp_drv(int b);
      return m_dir[b] & m_mode[b] & m_out[b];
   endfunction

   // monitor: pops an expectation each time the driver raises the event
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         @(chk_ev);
         it = sb_q.pop_front();
         case (it.kind)
            0: act = bus_rdata;
            1: act = pin_oe[it.bank*8 +: 8];
            default: act = pin_out[it.bank*8 +: 8];
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push(int kind, int bank, logic [7:0] exp, string tag);
      item_t it;
      it.kind = kind; it.bank = bank; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      #1;
      -> chk_ev;
      #1;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      for (int b = 0; b < 8; b++) begin
         if (a[7:4] == 4'(15 - b) && a[3:0] < 4'd4) begin
            case (a[1:0])
               2'd0: m_dir[b]  = d & msk(b);
               2'd1: m_out[b]  = d & msk(b);
               2'd3: m_mode[b] = d & msk(b);
               default: ;
            endcase
         end
      end
   endtask

   task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      bus_addr = a;
      push(0, 0, exp, tag);
   endtask

   task automatic pins_chk(int b, string tag);
      push(1, b, exp_oe(b), tag);
      push(2, b, exp_drv(b), tag);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 8; b++) begin m_dir[b] = 0; m_out[b] = 0; m_mode[b] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      rd(8'hF0, 8'h00, "R8 dir reset");
      rd(8'hF1, 8'h00, "R8 out reset");
      rd(8'h83, 8'h00, "R8 mode reset");
      for (int b = 0; b < 8; b++) pins_chk(b, "R8 R3 all inputs");

      // R7 R2 R5 bank0 six pins, open-drain, latch 0
      wr(8'hF0, 8'hFF);
      rd(8'hF0, 8'h3F, "R7 R2 bank0 dir mask");
      pins_chk(0, "R5 open-drain low");

      // R1 R4 R5 bank1 mixed modes
      wr(8'hE1, 8'hA5);
      wr(8'hE3, 8'h0F);
      wr(8'hE0, 8'hFF);
      rd(8'hE1, 8'hA5, "R2 R1 bank1 out");
      rd(8'hE3, 8'h0F, "R2 R1 bank1 mode");
      pins_chk(1, "R4 R5 mixed A5");
      wr(8'hE1, 8'h5A);
      pins_chk(1, "R4 R5 mixed 5A");

      // R10 strobe low changes nothing
      @(negedge clk);
      bus_addr = 8'hF1; bus_wdata = 8'hFF; bus_we = 1'b0;
      rd(8'hF1, 8'h00, "R10 no strobe");

      // R6 two-edge latency
      @(negedge clk);
      pin_in[24 +: 8] = 8'hC3;
      bus_addr = 8'hC2;
      rd(8'hC2, 8'h00, "R6 one edge old");
      rd(8'hC2, 8'hC3, "R6 two edges new");

      // R6 input reads pin while output
      pin_in[8 +: 8] = 8'h3C;
      repeat (2) @(negedge clk);
      rd(8'hE2, 8'h3C, "R6 input on output pin");

      // R7 partial banks on input
      pin_in[56 +: 8] = 8'hFF;
      pin_in[0 +: 8]  = 8'hFF;
      repeat (2) @(negedge clk);
      rd(8'h82, 8'h0F, "R7 bank7 input mask");
      rd(8'hF2, 8'h3F, "R7 bank0 input mask");

      // R9 ignored writes
      wr(8'hF2, 8'h00);
      rd(8'hF2, 8'h3F, "R9 input reg write ignored");
      wr(8'h45, 8'h77);
      wr(8'hF4, 8'h77);
      wr(8'h7F, 8'h77);
      rd(8'h45, 8'h00, "R9 hole 45");
      rd(8'hF4, 8'h00, "R9 hole F4");
      rd(8'h7F, 8'h00, "R9 hole 7F");
      rd(8'h8F, 8'h00, "R9 hole 8F");
      rd(8'hF0, 8'h3F, "R9 bank0 intact");
      for (int b = 0; b < 8; b++) pins_chk(b, "R9 pins intact");

      // R7 R4 small banks
      wr(8'hA3, 8'hFF);
      rd(8'hA3, 8'h1F, "R7 bank5 mode mask");
      wr(8'h83, 8'hFF);
      wr(8'h81, 8'hFF);
      wr(8'h80, 8'hFF);
      rd(8'h80, 8'h0F, "R1 R7 last bank dir");
      pins_chk(7, "R4 R7 last bank push-pull");

      // R5 open-drain release
      wr(8'h90, 8'h81);
      pins_chk(6, "R5 od pull low");
      wr(8'h91, 8'h80);
      pins_chk(6, "R5 od release");

      // R3 back to input
      wr(8'hE0, 8'h00);
      pins_chk(1, "R3 dir cleared");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule